// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical frame number when the translation cache in front of it misses. The requester presents an address space identifier, a virtual address and an access kind (read or write). The walker picks that address space's directory base, reads one 32-bit directory entry from memory, follows it to a second-level table and reads one table entry. It then answers with the frame number and the three attribute flags, or with a fault code that tells the requester not to fill its cache.

Each address space's directory base is loaded through a two-step register port. A first write selects the address space. A second write stores the base frame, which is the base address shifted right by 12. The address split is fixed: ten directory-index bits, ten table-index bits and a 12-bit page offset. The physical address width is a parameter from 32 to 34 bits, and it sets how many low entry bits form a frame number.

Only one walk runs at a time. A new request is taken only after the previous answer has been consumed. Memory reads go through a request port with valid/ready and come back on a response strobe.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0.
- R2: A config write with `cfg_sel`=0 stores `cfg_wdata[ASID_W-1:0]` as the selected address space, and higher bits are ignored. A write with `cfg_sel`=1 stores `cfg_wdata[PA_W-13:0]` as that space's base frame, and higher bits (attributes 31:29 included) are ignored.
- R3: The first read of a walk goes to base_frame·4096 + VA[31:22]·4.
- R4: The second read goes to frame(directory entry)·4096 + VA[21:12]·4, where frame(e) is e[PA_W-13:0].
- R5: A walk that ends without a fault answers `rsp_fault`=0, `rsp_pfn`=frame(table entry), `rsp_rd`=entry bit 31, `rsp_wr`=entry bit 30 and `rsp_ns`=entry bit 29.
- R6: A directory entry that is all zero, or whose bit 28 (next-level flag) is 0, ends the walk with `rsp_fault`=1 and no second read. Every fault answer carries zero frame and zero flags.
- R7: A table entry that is all zero ends the walk with `rsp_fault`=2.
- R8: A read access needs table-entry bit 31 and a write access needs bit 30. If the needed bit is 0, the answer is `rsp_fault`=3.
- R9: `req_ready` stays 0 from the accepted request until its answer is taken. The answer holds stable while `rsp_ready` is 0.
- R10: At most one memory read is outstanding, and `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready`.
- R11: Entry bits from PA_W-12 up to 28 do not reach the frame number.
- R12: Base frames are kept per address space, so programming one space does not change the walks of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_sel | input | 1 | 0 selects address space, 1 stores base frame |
| cfg_wdata | input | 32 | Config write data |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle and accepting |
| req_asid | input | ASID_W | Address space of the request |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Answer valid |
| rsp_ready | input | 1 | Answer consumed |
| rsp_fault | output | 2 | 0 ok, 1 directory, 2 table, 3 permission |
| rsp_pfn | output | PA_W-12 | Physical frame number |
| rsp_rd | output | 1 | Readable flag |
| rsp_wr | output | 1 | Writable flag |
| rsp_ns | output | 1 | Non-secure flag |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read back |

## Verification
The in-RTL properties check four things on every cycle. Requests and answers hold under back-pressure. No request is accepted while a walk is busy. Fault answers carry an empty payload, and a clean answer grants the right the access asked for. A data-register write lands in the selected address space. Only the scoreboard scenarios can show that entry addresses are formed from the right index bits and base, and that the directory cases without the next-level flag skip the second read. They also show that high entry bits are masked, that each fault code arises from its own cause, and that address spaces stay apart, because all of these depend on memory contents the properties cannot see.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   localparam int VA_W  = 32;
   localparam int ENT_W = 32;
   localparam int IDX_W = 10;
   localparam int OFS_W = 12;

   // attribute positions in a 32-bit entry
   localparam int BIT_RD   = 31;
   localparam int BIT_WR   = 30;
   localparam int BIT_NS   = 29;
   localparam int BIT_NEXT = 28;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_DIR  = 2'd1,
      FLT_TBL  = 2'd2,
      FLT_PERM = 2'd3
   } fault_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIR_REQ,
      ST_DIR_WAIT,
      ST_TBL_REQ,
      ST_TBL_WAIT,
      ST_RESP
   } walk_st_e;
endpackage

// File: rtl/ptw_base_regs.sv
module ptw_base_regs
   import ptw_pkg::*;
#(
   parameter int ASID_W = 7,
   parameter int PFN_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_sel,
   input  logic [31:0]       cfg_wdata,
   input  logic [ASID_W-1:0] rd_asid,
   output logic [PFN_W-1:0]  rd_base
);
   localparam int NUM_ASID = 1 << ASID_W;

   logic [ASID_W-1:0]   idx_q;
   logic [PFN_W-1:0]    base_q [NUM_ASID];
   logic [NUM_ASID-1:0] wr_hit;

   logic unused_cfg_hi;
   assign unused_cfg_hi = ^cfg_wdata[31:PFN_W];

   // one write-enable per address space
   for (genvar g = 0; g < NUM_ASID; g++) begin : g_wsel
      assign wr_hit[g] = cfg_wr && cfg_sel && (idx_q == ASID_W'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         for (int a = 0; a < NUM_ASID; a++) base_q[a] <= '0;
      end else begin
         if (cfg_wr && !cfg_sel) idx_q <= cfg_wdata[ASID_W-1:0];
         for (int a = 0; a < NUM_ASID; a++)
            if (wr_hit[a]) base_q[a] <= cfg_wdata[PFN_W-1:0];
      end
   end

   assign rd_base = base_q[rd_asid];

   // R2: a data write lands in the space selected at that moment
   a_r2_base_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_sel) |=> base_q[$past(idx_q)] == $past(cfg_wdata[PFN_W-1:0]));
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
   import ptw_pkg::*;
#(
   parameter int PFN_W  = 20,
   parameter bit IS_DIR = 1'b1
) (
   input  logic [ENT_W-1:0] entry,
   input  logic             is_write,
   output logic             ok,
   output fault_e           fault,
   output logic [PFN_W-1:0] frame
);
   assign frame = entry[PFN_W-1:0];

   if (IS_DIR) begin : g_dir
      logic unused_w;
      assign unused_w = is_write;
      always_comb begin
         ok    = (entry != '0) && entry[BIT_NEXT];
         fault = ok ? FLT_NONE : FLT_DIR;
      end
   end else begin : g_tbl
      logic granted;
      assign granted = is_write ? entry[BIT_WR] : entry[BIT_RD];
      always_comb begin
         if (entry == '0) begin
            ok    = 1'b0;
            fault = FLT_TBL;
         end else if (!granted) begin
            ok    = 1'b0;
            fault = FLT_PERM;
         end else begin
            ok    = 1'b1;
            fault = FLT_NONE;
         end
      end
   end
endmodule

// File: rtl/ptw_engine.sv
module ptw_engine
   import ptw_pkg::*;
#(
   parameter int PA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [VA_W-1:0]       req_va,
   input  logic                  req_write,
   input  logic [PA_W-OFS_W-1:0] base_frame,
   output logic                  mem_req_valid,
   input  logic                  mem_req_ready,
   output logic [PA_W-1:0]       mem_req_addr,
   input  logic                  mem_rsp_valid,
   input  logic [ENT_W-1:0]      mem_rsp_data,
   output logic                  rsp_valid,
   input  logic                  rsp_ready,
   output logic [1:0]            rsp_fault,
   output logic [PA_W-OFS_W-1:0] rsp_pfn,
   output logic                  rsp_rd,
   output logic                  rsp_wr,
   output logic                  rsp_ns
);
   localparam int PFN_W = PA_W - OFS_W;

   walk_st_e              st_q;
   logic [VA_W-1:OFS_W]   va_q;
   logic                  wr_q;
   logic [PA_W-1:0]       addr_q;
   fault_e                flt_q;
   logic [PFN_W-1:0]      pfn_q;
   logic                  rd_q, wrf_q, ns_q;

   logic                  dir_ok, tbl_ok;
   fault_e                unused_dir_flt, tbl_flt;
   logic [PFN_W-1:0]      dir_frame, tbl_frame;

   logic unused_ofs;
   assign unused_ofs = ^req_va[OFS_W-1:0];

   ptw_entry_eval #(.PFN_W(PFN_W), .IS_DIR(1'b1)) u_dir_eval (
      .entry(mem_rsp_data), .is_write(wr_q), .ok(dir_ok),
      .fault(unused_dir_flt), .frame(dir_frame));

   ptw_entry_eval #(.PFN_W(PFN_W), .IS_DIR(1'b0)) u_tbl_eval (
      .entry(mem_rsp_data), .is_write(wr_q), .ok(tbl_ok),
      .fault(tbl_flt), .frame(tbl_frame));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         va_q   <= '0;
         wr_q   <= 1'b0;
         addr_q <= '0;
         flt_q  <= FLT_NONE;
         pfn_q  <= '0;
         rd_q   <= 1'b0;
         wrf_q  <= 1'b0;
         ns_q   <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (req_valid) begin
               va_q   <= req_va[VA_W-1:OFS_W];
               wr_q   <= req_write;
               addr_q <= {base_frame, req_va[VA_W-1:VA_W-IDX_W], 2'b00};
               st_q   <= ST_DIR_REQ;
            end
            ST_DIR_REQ: if (mem_req_ready) st_q <= ST_DIR_WAIT;
            ST_DIR_WAIT: if (mem_rsp_valid) begin
               if (dir_ok) begin
                  addr_q <= {dir_frame, va_q[OFS_W+IDX_W-1:OFS_W], 2'b00};
                  st_q   <= ST_TBL_REQ;
               end else begin
                  flt_q <= FLT_DIR;
                  pfn_q <= '0;
                  rd_q  <= 1'b0;
                  wrf_q <= 1'b0;
                  ns_q  <= 1'b0;
                  st_q  <= ST_RESP;
               end
            end
            ST_TBL_REQ: if (mem_req_ready) st_q <= ST_TBL_WAIT;
            ST_TBL_WAIT: if (mem_rsp_valid) begin
               flt_q <= tbl_flt;
               pfn_q <= tbl_ok ? tbl_frame : '0;
               rd_q  <= tbl_ok && mem_rsp_data[BIT_RD];
               wrf_q <= tbl_ok && mem_rsp_data[BIT_WR];
               ns_q  <= tbl_ok && mem_rsp_data[BIT_NS];
               st_q  <= ST_RESP;
            end
            ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (st_q == ST_IDLE);
   assign mem_req_valid = (st_q == ST_DIR_REQ) || (st_q == ST_TBL_REQ);
   assign mem_req_addr  = addr_q;
   assign rsp_valid     = (st_q == ST_RESP);
   assign rsp_fault     = flt_q;
   assign rsp_pfn       = pfn_q;
   assign rsp_rd        = rd_q;
   assign rsp_wr        = wrf_q;
   assign rsp_ns        = ns_q;

   // R9: an accepted request blocks the next one
   a_r9_no_second_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R9: answer held under back-pressure
   a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_pfn) && $stable(rsp_fault)
         && $stable({rsp_rd, rsp_wr, rsp_ns}));

   // R10: memory request held until taken
   a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));

   // R6: a fault answer carries nothing
   a_r6_fault_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_pfn == '0) && !rsp_rd && !rsp_wr && !rsp_ns);

   // R8: a clean answer grants the requested right
   a_r8_right_granted: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == FLT_NONE) |-> (wr_q ? rsp_wr : rsp_rd));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int PA_W   = 32,
   parameter int ASID_W = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wr,
   input  logic                  cfg_sel,
   input  logic [31:0]           cfg_wdata,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic [ASID_W-1:0]     req_asid,
   input  logic [31:0]           req_va,
   input  logic                  req_write,
   output logic                  rsp_valid,
   input  logic                  rsp_ready,
   output logic [1:0]            rsp_fault,
   output logic [PA_W-13:0]      rsp_pfn,
   output logic                  rsp_rd,
   output logic                  rsp_wr,
   output logic                  rsp_ns,
   output logic                  mem_req_valid,
   input  logic                  mem_req_ready,
   output logic [PA_W-1:0]       mem_req_addr,
   input  logic                  mem_rsp_valid,
   input  logic [31:0]           mem_rsp_data
);
   localparam int PFN_W = PA_W - OFS_W;

   if (PA_W < 32 || PA_W > 34) begin : g_bad_pa
      $error("ptw_walker: PA_W must lie in 32..34");
   end
   if (ASID_W < 1 || ASID_W > 7) begin : g_bad_asid
      $error("ptw_walker: ASID_W must lie in 1..7");
   end

   logic [PFN_W-1:0] base_frame;

   ptw_base_regs #(.ASID_W(ASID_W), .PFN_W(PFN_W)) u_base (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .rd_asid(req_asid), .rd_base(base_frame));

   ptw_engine #(.PA_W(PA_W)) u_engine (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .req_write(req_write), .base_frame(base_frame),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
      .rsp_pfn(rsp_pfn), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ns(rsp_ns));
endmodule

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;
   localparam int PA_W   = 32;
   localparam int ASID_W = 7;
   localparam int PFN_W  = PA_W - 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_wr, cfg_sel;
   logic [31:0]       cfg_wdata;
   logic              req_valid, req_ready, req_write;
   logic [ASID_W-1:0] req_asid;
   logic [31:0]       req_va;
   logic              rsp_valid, rsp_ready, rsp_rd, rsp_wr, rsp_ns;
   logic [1:0]        rsp_fault;
   logic [PFN_W-1:0]  rsp_pfn;
   logic              mem_req_valid, mem_req_ready, mem_rsp_valid;
   logic [PA_W-1:0]   mem_req_addr;
   logic [31:0]       mem_rsp_data;

   ptw_walker #(.PA_W(PA_W), .ASID_W(ASID_W)) i_ptw_walker (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_asid(req_asid), .req_va(req_va),
      .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_fault(rsp_fault), .rsp_pfn(rsp_pfn), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
      .rsp_ns(rsp_ns), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

   always #4 clk = ~clk;

   typedef struct {
      logic [1:0]       fault;
      logic [PFN_W-1:0] pfn;
      logic [2:0]       flags;
      string            tag;
   } exp_t;
   typedef struct {
      logic [PA_W-1:0] addr;
      string           tag;
   } exp_addr_t;

   exp_t             exp_q[$];
   exp_addr_t        addr_q[$];
   logic [31:0]      mem_m [logic [PA_W-1:0]];
   logic [PFN_W-1:0] base_m [1 << ASID_W];
   logic [ASID_W-1:0] idx_m;
   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   function automatic logic [31:0] rd_m(input logic [PA_W-1:0] a);
      return mem_m.exists(a) ? mem_m[a] : 32'h0;
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic cfg(input logic sel, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
      if (!sel) idx_m = d[ASID_W-1:0];
      else base_m[idx_m] = d[PFN_W-1:0];
   endtask

   // driver: compute expectation from the requirements, push, then issue
   task automatic walk(input logic [ASID_W-1:0] asid, input logic [31:0] va,
                       input logic wr, input string tag);
      exp_t e;
      exp_addr_t ea;
      logic [31:0] d, t;
      logic [PA_W-1:0] da, ta;
      da = {base_m[asid], va[31:22], 2'b00};          // R3
      ea.addr = da; ea.tag = tag; addr_q.push_back(ea);
      d = rd_m(da);
      e.tag = tag; e.fault = 2'd0; e.pfn = '0; e.flags = 3'b000;
      if (d == 32'h0 || !d[28]) e.fault = 2'd1;        // R6
      else begin
         ta = {d[PFN_W-1:0], va[21:12], 2'b00};        // R4
         ea.addr = ta; addr_q.push_back(ea);
         t = rd_m(ta);
         if (t == 32'h0) e.fault = 2'd2;                // R7
         else if (wr ? !t[30] : !t[31]) e.fault = 2'd3; // R8
         else begin                                     // R5, R11
            e.pfn = t[PFN_W-1:0];
            e.flags = t[31:29];
         end
      end
      exp_q.push_back(e);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_asid = asid; req_va = va; req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   // memory responder with a stall pattern; checks every read address
   initial begin
      logic hs;
      logic [PA_W-1:0] hs_addr;
      int cnt;
      exp_addr_t ea;
      hs = 1'b0; hs_addr = '0; cnt = 0;
      mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (hs) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data = rd_m(hs_addr);
            hs = 1'b0;
         end
         cnt++;
         mem_req_ready = (cnt % 3 != 0);
         if (mem_req_valid && mem_req_ready) begin
            hs = 1'b1;
            hs_addr = mem_req_addr;
            if (addr_q.size() == 0) chk("R6/R10", "unexpected read", 64'(mem_req_addr), 64'h0);
            else begin
               ea = addr_q.pop_front();
               chk(ea.tag, "read address", 64'(mem_req_addr), 64'(ea.addr));
            end
         end
      end
   end

   // monitor: stall each answer one cycle, then pop and compare
   initial begin
      int k;
      logic [PFN_W-1:0] held_pfn;
      logic [1:0] held_flt;
      exp_t e;
      k = 0; held_pfn = '0; held_flt = '0;
      rsp_ready = 1'b0;
      forever begin
         @(negedge clk);
         rsp_ready = 1'b0;
         if (rsp_valid) begin
            k++;
            if (k % 2 == 1) begin
               chk("R9", "req_ready while answer pending", 64'(req_ready), 64'h0);
               held_pfn = rsp_pfn; held_flt = rsp_fault;
            end else begin
               rsp_ready = 1'b1;
               chk("R9", "held pfn", 64'(rsp_pfn), 64'(held_pfn));
               chk("R9", "held fault", 64'(rsp_fault), 64'(held_flt));
               if (exp_q.size() == 0) chk("R9", "unexpected answer", 64'h1, 64'h0);
               else begin
                  e = exp_q.pop_front();
                  chk(e.tag, "fault", 64'(rsp_fault), 64'(e.fault));
                  chk(e.tag, "pfn", 64'(rsp_pfn), 64'(e.pfn));
                  chk(e.tag, "rd/wr/ns", 64'({rsp_rd, rsp_wr, rsp_ns}), 64'(e.flags));
                  chk(e.tag, "reads left over", 64'(addr_q.size()), 64'h0);
               end
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
   end

   initial begin
      cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
      req_valid = 1'b0; req_asid = '0; req_va = '0; req_write = 1'b0;
      idx_m = '0;
      for (int a = 0; a < (1 << ASID_W); a++) base_m[a] = '0;

      // tables for address space 5 (base frame 0x100)
      mem_m[32'h0010_0004] = 32'hF000_0200;
      mem_m[32'h0020_000C] = 32'hEFF1_2345;
      mem_m[32'h0020_0010] = 32'hA000_0777;
      mem_m[32'h0020_0014] = 32'h4000_0888;
      mem_m[32'h0010_000C] = 32'hE000_0300;
      // tables for address space 127 (base frame 0x300)
      mem_m[32'h0030_0004] = 32'h9000_0400;
      mem_m[32'h0040_000C] = 32'h8000_0055;
      mem_m[32'h0030_0FFC] = 32'hF000_0500;
      mem_m[32'h0050_0004] = 32'hC000_0001;

      repeat (3) @(negedge clk);
      chk("R1", "req_ready in reset", 64'(req_ready), 64'h1);
      chk("R1", "rsp_valid in reset", 64'(rsp_valid), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'h0);
      chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'h0);

      cfg(1'b0, 32'd5);
      cfg(1'b1, 32'hE000_0100);                     // R2: attribute bits dropped
      walk(7'd5, 32'h0040_3000, 1'b0, "R2 R3 R4 R5 R11 read");
      walk(7'd5, 32'h0040_3ABC, 1'b1, "R5 R11 write");
      walk(7'd5, 32'h0040_4000, 1'b0, "R8 read-only entry read");
      walk(7'd5, 32'h0040_4000, 1'b1, "R8 read-only entry write");
      walk(7'd5, 32'h0040_5000, 1'b0, "R8 write-only entry read");
      walk(7'd5, 32'h0080_0000, 1'b0, "R6 zero directory entry");
      walk(7'd5, 32'h00C0_0000, 1'b0, "R6 directory without next flag");
      walk(7'd5, 32'h0040_6000, 1'b0, "R7 zero table entry");

      cfg(1'b0, 32'd127);
      cfg(1'b1, 32'h0000_0300);
      walk(7'd127, 32'h0040_3000, 1'b0, "R12 second space");
      walk(7'd127, 32'hFFC0_1000, 1'b1, "R3 R4 top directory slot");
      walk(7'd5, 32'h0040_3000, 1'b0, "R12 first space untouched");
      walk(7'd0, 32'h0040_3000, 1'b0, "R12 unprogrammed space");

      cfg(1'b0, 32'hFFFF_FF85);                     // R2: index high bits dropped, selects 5
      cfg(1'b1, 32'h0000_0180);
      walk(7'd5, 32'h0040_3000, 1'b0, "R2 reselect and rebase");
      walk(7'd127, 32'h0040_3000, 1'b0, "R12 other space after rebase");

      repeat (4) @(negedge clk);
      chk("R9", "idle at end", 64'(req_ready), 64'h1);
      summary();
   end
endmodule